// File: doc/BRIEF.md
# Receive Buffer with Host-Link Wake

This block sits on the receive path between a line-side byte stream and a host-side output that may be asleep in a low-power state. Each arriving frame goes into a small FIFO, so nothing is lost while the host side comes back. The first byte of every frame raises a wake request. The request stays up until the host reports ready and the buffer has drained.

The forwarding policy depends on the link rate, which is captured at each start of frame and stored with every entry of that frame. A gigabit frame is forwarded cut-through: its bytes leave as soon as they are stored and the host is ready. A 10 or 100 Mb/s frame is held until its last byte is in the buffer and is then sent as a burst. When the buffer cannot hold a frame, the block closes that frame with an error-tagged end marker and skips the rest of it. A frame that finds the buffer full is dropped entirely. Each truncated or dropped frame adds one to a drop counter.

Top module: `rx_wake_buffer`

## Requirements
- R1: An accepted byte with `in_sof` high makes `wake_req` high from the next clock edge.
- R2: While `host_ready` is low, `wake_req` stays high once set, and the buffer holds its contents.
- R3: `wake_req` returns low within two cycles after the buffer has emptied, no frame is being received, and `host_ready` is high.
- R4: With `speed` = 2'b10 (1 Gb/s) at start of frame and `host_ready` high, the first byte appears on the output in the cycle after it is written, with `out_sof` high.
- R5: With `speed` = 2'b00 (10 Mb/s) or 2'b01 (100 Mb/s) at start of frame, no byte of that frame is output until its end-of-frame byte has been written. The frame then begins in the cycle after that write.
- R6: `speed` is sampled only at start of frame. A change later in the frame does not alter that frame's forwarding mode.
- R7: Bytes leave in arrival order with their `out_sof`/`out_eof` markers unchanged and `out_err` low for frames that fit.
- R8: If a non-final byte arrives when one free entry remains (occupancy DEPTH-1), that byte is stored with `out_eof` and `out_err` high. The remaining bytes of the frame, up to and including its `in_eof`, are discarded, and `drop_count` increases by one.
- R9: A start-of-frame byte that arrives while the buffer is full (occupancy DEPTH) causes the whole frame to be discarded, and `drop_count` increases by one.
- R10: `out_valid` is high only while `host_ready` is high. Each cycle with `out_valid` high consumes one entry.
- R11: After reset, `wake_req`, `out_valid` and `drop_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed | input | 2 | Link rate: 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1 Gb/s |
| in_valid | input | 1 | Line-side byte present |
| in_data | input | 8 | Line-side byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| host_ready | input | 1 | Host-side link recovered and accepting |
| wake_req | output | 1 | Request to wake the host-side link |
| out_valid | output | 1 | Output byte present (consumed the same cycle) |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte starts a frame |
| out_eof | output | 1 | Output byte ends a frame |
| out_err | output | 1 | Frame ended early because of overflow |
| drop_count | output | CNT_W | Frames truncated or dropped |

## Verification
A wrong frame-completion count appears at once. Either a low-speed frame starts on the output before its end byte is stored, or it waits past the cycle after that byte. Corrupted pointers or occupancy show up as reordered, missing or repeated bytes, or as misplaced markers, in the next drained frame. Overflow handling is driven to the exact boundary entry, so a wrong threshold moves the error-tagged end by one byte and shifts the drop count.

// File: rtl/rxw_pkg.sv
// Shared types for the receive wake buffer.
// Assumes byte-wide streams; the speed code is fixed by the port contract.
package rxw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10
    } speed_e;

    // One buffered byte together with its frame tags.
    typedef struct packed {
        logic              hold_whole; // store-and-forward frame
        logic              err;        // frame cut short by overflow
        logic              sof;
        logic              eof;
        logic [BYTE_W-1:0] data;
    } entry_t;
endpackage

// File: rtl/rxw_fifo.sv
// Entry storage with occupancy and a count of complete frames held.
// Assumes DEPTH is a power of two; the caller never writes when full
// and never reads when empty.
module rxw_fifo
    import rxw_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  entry_t      wr_entry,
    input  logic        rd_en,
    output entry_t      head,
    output logic [AW:0] count,
    output logic        empty,
    output logic        frame_ready
);
    entry_t          mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [AW:0]     frames;

    // Store incoming entries.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_entry;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(wr_en) - (AW+1)'(rd_en);
        end
    end

    // Count frames whose end byte is stored but not yet read.
    always_ff @(posedge clk) begin
        if (!rst_n) frames <= '0;
        else frames <= frames + (AW+1)'(wr_en && wr_entry.eof)
                              - (AW+1)'(rd_en && head.eof);
    end

    assign head        = mem[rd_ptr];
    assign empty       = (count == '0);
    assign frame_ready = (frames != '0);
endmodule

// File: rtl/rxw_admit.sv
// Write-side control: latches the forwarding mode at start of frame,
// reserves the last entry for an error-tagged terminator, discards the
// rest of an overflowing frame and counts affected frames.
// Assumes bytes outside a frame (no preceding sof) carry no meaning.
module rxw_admit
    import rxw_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [1:0]        speed,
    input  logic [AW:0]       count,
    output logic              wr_en,
    output entry_t            wr_entry,
    output logic              busy,
    output logic [CNT_W-1:0]  drop_count
);
    logic in_frame, discarding, mode_sf;
    logic start, cont, full, last_slot, trunc, kill, new_sf;

    assign start     = in_valid && in_sof;
    assign cont      = in_valid && !in_sof && in_frame;
    assign full      = (count == (AW+1)'(DEPTH));
    assign last_slot = (count == (AW+1)'(DEPTH-1));
    assign new_sf    = (speed != SPD_1000);

    // Decide per byte whether to store, terminate or drop.
    always_comb begin
        wr_en = 1'b0;
        trunc = 1'b0;
        kill  = 1'b0;
        if (start || cont) begin
            if (full)                     kill  = 1'b1;
            else if (last_slot && !in_eof) trunc = 1'b1;
            else                           wr_en = 1'b1;
        end
        if (trunc) wr_en = 1'b1;
    end

    // Build the stored entry.
    always_comb begin
        wr_entry.data       = in_data;
        wr_entry.sof        = start;
        wr_entry.eof        = in_eof || trunc;
        wr_entry.err        = trunc;
        wr_entry.hold_whole = start ? new_sf : mode_sf;
    end

    // Track frame state, forwarding mode and drop count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame   <= 1'b0;
            discarding <= 1'b0;
            mode_sf    <= 1'b0;
            drop_count <= '0;
        end else begin
            if (start) mode_sf <= new_sf;
            if (start || cont) in_frame <= wr_en && !trunc && !in_eof;
            if (kill || trunc)              discarding <= !in_eof;
            else if (start)                 discarding <= 1'b0;
            else if (in_valid && in_eof)    discarding <= 1'b0;
            if (kill || trunc) drop_count <= drop_count + 1'b1;
        end
    end

    assign busy = in_frame || discarding;
endmodule

// File: rtl/rxw_wake.sv
// Wake request generator: set by a start of frame, released once the
// host is ready, the buffer is empty and no frame is arriving.
module rxw_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_seen,
    input  logic host_ready,
    input  logic empty,
    input  logic busy,
    output logic wake_req
);
    // Hold the request across the host recovery period.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     wake_req <= 1'b0;
        else if (sof_seen)                              wake_req <= 1'b1;
        else if (host_ready && empty && !busy)          wake_req <= 1'b0;
    end
endmodule

// File: rtl/rx_wake_buffer.sv
// Receive buffer with host wake. Frames are buffered, a start of frame
// requests host wake-up, and forwarding is cut-through at 1 Gb/s or
// store-and-forward below it. Assumes the host consumes a byte in
// every cycle it reports ready and out_valid is high.
module rx_wake_buffer
    import rxw_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        speed,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              host_ready,
    output logic              wake_req,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic [CNT_W-1:0]  drop_count
);
    entry_t      wr_entry, head;
    logic        wr_en, busy, empty, frame_ready;
    logic [AW:0] count;

    rxw_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_admit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .speed(speed), .count(count),
        .wr_en(wr_en), .wr_entry(wr_entry), .busy(busy),
        .drop_count(drop_count)
    );

    rxw_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
        .rd_en(out_valid), .head(head), .count(count), .empty(empty),
        .frame_ready(frame_ready)
    );

    rxw_wake u_wake (
        .clk(clk), .rst_n(rst_n), .sof_seen(in_valid && in_sof),
        .host_ready(host_ready), .empty(empty), .busy(busy),
        .wake_req(wake_req)
    );

    // Release the head entry when the host is up and its frame may go.
    always_comb begin
        out_valid = host_ready && !empty && (!head.hold_whole || frame_ready);
        out_data  = head.data;
        out_sof   = out_valid && head.sof;
        out_eof   = out_valid && head.eof;
        out_err   = out_valid && head.err;
    end
endmodule

// File: rtl/rx_wake_buffer_chk.sv
// Port-level properties of the receive wake buffer, bound to the top.
module rx_wake_buffer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       speed,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             in_sof,
    input logic             in_eof,
    input logic             host_ready,
    input logic             wake_req,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_sof,
    input logic             out_eof,
    input logic             out_err,
    input logic [CNT_W-1:0] drop_count
);
    a_r1_wake_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> wake_req);

    a_r2_wake_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !host_ready) |=> wake_req);

    a_r10_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> host_ready);

    a_r8_err_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_eof && out_valid));

    a_r9_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

    a_r11_reset_clear: assert property (@(posedge clk)
        !$past(rst_n) |-> (drop_count == '0 && !wake_req));
endmodule

bind rx_wake_buffer rx_wake_buffer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_rx_wake_buffer.sv
// Self-checking bench: sweeps speed codes and frame lengths, then the
// wake hold, truncation and whole-frame drop boundaries.
module sim_rx_wake_buffer;
    localparam int DEPTH = 8;
    localparam int CNT_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] speed = 2'b00;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       host_ready = 1'b0;
    logic       wake_req, out_valid, out_sof, out_eof, out_err;
    logic [7:0] out_data;
    logic [CNT_W-1:0] drop_count;

    int errors = 0, checks = 0, cyc = 0;
    logic [7:0] cap_d [0:255];
    logic [2:0] cap_f [0:255];
    logic [7:0] exp_d [0:255];
    logic [2:0] exp_f [0:255];
    int ncap = 0, nexp = 0;

    always #2.5 clk = ~clk;

    rx_wake_buffer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .speed(speed), .in_valid(in_valid),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .host_ready(host_ready), .wake_req(wake_req), .out_valid(out_valid),
        .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .out_err(out_err), .drop_count(drop_count)
    );

    // Record every consumed output byte mid-cycle.
    always @(negedge clk) begin
        if (rst_n && out_valid && ncap < 256) begin
            cap_d[ncap] = out_data;
            cap_f[ncap] = {out_sof, out_eof, out_err};
            ncap++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    task automatic add_exp(input logic [7:0] d, input logic [2:0] f);
        exp_d[nexp] = d;
        exp_f[nexp] = f;
        nexp++;
    endtask

    // Send one frame; optionally check timing against the forwarding mode.
    task automatic send_frame(input int len, input int spd0, input int spd_rest,
                              input int base, input bit timing, input bit record);
        bit sf = (spd0 != 2);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = 8'(base + i);
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            speed    = (i == 0) ? 2'(spd0) : 2'(spd_rest);
            if (record) add_exp(8'(base + i), {i == 0, i == len - 1, 1'b0});
            if (i >= 1) begin
                @(negedge clk);
                if (i == 1) chk(wake_req == 1'b1, "R1 wake after sof", wake_req, 1);
                if (timing && sf)
                    chk(out_valid == 1'b0, "R5 held until eof", out_valid, 0);
                if (timing && !sf && i == 1)
                    chk(out_valid && out_sof, "R4 cut-through start", out_valid, 1);
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        if (len == 1) chk(wake_req == 1'b1, "R1 wake after sof", wake_req, 1);
        if (timing && (sf || len == 1))
            chk(out_valid && out_sof, "R5 release after eof", out_valid, 1);
    endtask

    task automatic drain_compare(input string req);
        int n = 0;
        while (ncap < nexp && n < 60) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(ncap == nexp, req, ncap, nexp);
        for (int k = 0; k < nexp && k < ncap; k++) begin
            chk(cap_d[k] == exp_d[k], req, cap_d[k], exp_d[k]);
            chk(cap_f[k] == exp_f[k], req, cap_f[k], exp_f[k]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        chk(wake_req == 1'b0, "R11 wake_req", wake_req, 0);
        chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
        chk(drop_count == '0, "R11 drop_count", drop_count, 0);

        // R4 R5 R7: sweep speed codes and frame lengths with host ready.
        @(posedge clk); #1 host_ready = 1'b1;
        for (int s = 0; s < 3; s++) begin
            for (int len = 1; len <= 6; len++) begin
                ncap = 0; nexp = 0;
                send_frame(len, s, s, 16 * len + s, 1'b1, 1'b1);
                drain_compare("R7 order and markers");
            end
        end

        // R6: speed changes to gigabit after sof; frame stays held.
        ncap = 0; nexp = 0;
        send_frame(5, 0, 2, 8'hA0, 1'b1, 1'b1);
        drain_compare("R6 latched speed");
        chk(drop_count == '0, "R8 no false drop", drop_count, 0);
        chk(wake_req == 1'b0, "R3 wake released", wake_req, 0);

        // R8: truncation at the last free entry while the host sleeps.
        @(posedge clk); #1 host_ready = 1'b0;
        ncap = 0; nexp = 0;
        send_frame(12, 2, 2, 8'h40, 1'b0, 1'b0);
        for (int k = 0; k < DEPTH - 1; k++) add_exp(8'(8'h40 + k), {k == 0, 1'b0, 1'b0});
        add_exp(8'(8'h40 + DEPTH - 1), 3'b011);
        repeat (4) begin
            @(negedge clk);
            chk(wake_req == 1'b1, "R2 wake held", wake_req, 1);
            chk(out_valid == 1'b0, "R10 no output while asleep", out_valid, 0);
        end
        chk(drop_count == 8'd1, "R8 drop count", drop_count, 1);
        @(posedge clk); #1 host_ready = 1'b1;
        drain_compare("R8 truncated frame");
        chk(wake_req == 1'b0, "R3 wake released", wake_req, 0);

        // R9: fill exactly to DEPTH, then a frame that finds it full.
        @(posedge clk); #1 host_ready = 1'b0;
        ncap = 0; nexp = 0;
        send_frame(DEPTH, 1, 1, 8'h80, 1'b0, 1'b1);
        chk(drop_count == 8'd1, "R8 exact fit not dropped", drop_count, 1);
        send_frame(3, 1, 1, 8'hC0, 1'b0, 1'b0);
        @(negedge clk);
        chk(drop_count == 8'd2, "R9 full drop", drop_count, 2);
        chk(out_valid == 1'b0, "R10 no output while asleep", out_valid, 0);
        @(posedge clk); #1 host_ready = 1'b1;
        drain_compare("R9 surviving frame");
        chk(wake_req == 1'b0, "R3 wake released", wake_req, 0);

        summary();
    end
endmodule